// File: doc/BRIEF.md
# Line remote error indication monitor

This block watches the line-overhead M1 byte of each received STS-3 frame. The far end places in that byte the number of errors it saw in the line parity of an earlier frame. That number, the line remote error indication, is zero when the far end saw no errors and lies between 1 and 24 otherwise. Whenever a frame carries a non-zero value, the block does three things. It sets a detection status bit. It pulls an active-low interrupt pin if that bit is enabled. It adds the error count, clamped to 24, to a saturating 32-bit accumulator.

Upstream logic supplies a frame strobe and a valid strobe that comes with the M1 byte. The M1 input has no ready signal. The block takes a byte in any cycle, so it never applies back-pressure. Only the first valid byte of a frame is evaluated.

A byte-wide register port gives access to the status bit, the enable bit and the accumulator. Reading the status byte clears the status bit. Reading the top accumulator byte freezes the whole count, so that the three lower bytes read back one coherent value. That same read also restarts the live accumulator from zero.

Top module: `rei_line_monitor`

## Requirements
- R1: Only the first `m1_valid` byte after a `frame_start` is evaluated, and the same holds for the first one after reset. A byte that arrives together with `frame_start` belongs to the new frame. Further bytes in the same frame change no status bit and no count.
- R2: An evaluated M1 byte of value 0 sets no status bit and leaves the accumulator unchanged.
- R3: An evaluated non-zero M1 byte sets the detection status bit. That bit is bit 5 of address 0, and the other bits of address 0 read 0.
- R4: An evaluated non-zero M1 byte adds its value to the accumulator. Values above 24 are added as 24.
- R5: The accumulator saturates at all ones of its `CNT_W` bits and never wraps.
- R6: A read of address 4 returns accumulator bits 31:24. The same read copies the accumulator into a snapshot and restarts the live count at zero, plus any amount added in that same cycle. Addresses 5, 6 and 7 return snapshot bits 23:16, 15:8 and 7:0. When `CNT_W` is below 32, the count is zero-extended.
- R7: A read of address 0 returns the status bit and clears it on the following edge.
- R8: If an event arrives in the same cycle as a read of address 0, the read returns the old status and the bit stays set.
- R9: The interrupt enable is bit 5 of address 1. It is written through `wr_en`/`wr_addr`/`wr_data` and reads back at bit 5 of address 1, with every other bit reading 0.
- R10: `irq_n` is low exactly when the status bit and the enable bit are both 1.
- R11: After reset, the status and enable bits are 0, the accumulator and snapshot are 0, `irq_n` is 1 and `rd_data` is 0.
- R12: `rd_data` is updated one clock after `rd_en` and holds its value between reads. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start of a received frame |
| m1_valid | input | 1 | M1 byte is valid this cycle |
| m1_byte | input | 8 | Received M1 byte |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach from the ports is accumulator saturation. A full 32-bit count needs about 179 million frames of value 24. To reach it, the bench drives a second instance with `CNT_W` set to 10 from the same stimulus, and pushes that instance past 1023 with a burst of maximum-value frames. The bench then reads the frozen count back one byte at a time. Directed cycles also place an event in the exact cycle of a status read and of a snapshot read. Random traffic then mixes frame strobes, repeated M1 bytes and reads.

// File: rtl/rei_mon_pkg.sv
package rei_mon_pkg;
  localparam int ADDR_W  = 3;
  localparam int AMT_W   = 5;
  localparam int REI_MAX = 24;
  localparam int STS_BIT = 5;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT3   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT2   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT1   = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd7;

  function automatic logic [AMT_W-1:0] clamp_rei(input logic [7:0] m);
    if (m > 8'(REI_MAX)) return AMT_W'(REI_MAX);
    return m[AMT_W-1:0];
  endfunction
endpackage

// File: rtl/rei_extract.sv
module rei_extract
  import rei_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             m1_valid,
  input  logic [7:0]       m1_byte,
  output logic             evt,
  output logic [AMT_W-1:0] evt_amt
);
  logic armed_q;
  logic take;

  // One evaluation per frame; a byte alongside the strobe opens the new frame
  assign take    = m1_valid && (armed_q || frame_start);
  assign evt     = take && (m1_byte != 8'd0);
  assign evt_amt = clamp_rei(m1_byte);

  always_ff @(posedge clk) begin
    if (!rst_n)           armed_q <= 1'b1;
    else if (frame_start) armed_q <= !m1_valid;
    else if (m1_valid)    armed_q <= 1'b0;
  end
endmodule

// File: rtl/rei_accum.sv
module rei_accum
  import rei_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [AMT_W-1:0] evt_amt,
  input  logic             take_snap,
  output logic [CNT_W-1:0] live,
  output logic [31:0]      snap
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = take_snap ? '0 : live;
    sum  = {1'b0, base} + SUM_W'(evt_amt);
    if (!evt)              nxt = base;
    else if (sum[CNT_W])   nxt = '1;
    else                   nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      snap <= '0;
    end else begin
      live <= nxt;
      if (take_snap) snap <= 32'(live);
    end
  end
endmodule

// File: rtl/rei_irq.sv
module rei_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic sts_read,
  input  logic en_write,
  input  logic en_value,
  output logic sts,
  output logic en,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= 1'b0;
      en  <= 1'b0;
    end else begin
      if (evt)           sts <= 1'b1;
      else if (sts_read) sts <= 1'b0;
      if (en_write)      en  <= en_value;
    end
  end

  assign irq_n = ~(sts & en);
endmodule

// File: rtl/rei_line_monitor.sv
module rei_line_monitor
  import rei_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              m1_valid,
  input  logic [7:0]        m1_byte,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              irq_n
);
  logic             evt;
  logic [AMT_W-1:0] evt_amt;
  logic [CNT_W-1:0] live_cnt;
  logic [31:0]      snap;
  logic [31:0]      live32;
  logic             sts, irq_en;
  logic             rd_sts, rd_top;
  logic [7:0]       rd_mux;

  assign rd_sts = rd_en && (rd_addr == A_STATUS);
  assign rd_top = rd_en && (rd_addr == A_CNT3);
  assign live32 = 32'(live_cnt);

  rei_extract u_ext (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .m1_valid(m1_valid), .m1_byte(m1_byte), .evt(evt), .evt_amt(evt_amt)
  );

  rei_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .evt(evt), .evt_amt(evt_amt),
    .take_snap(rd_top), .live(live_cnt), .snap(snap)
  );

  rei_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sts_read(rd_sts),
    .en_write(wr_en && (wr_addr == A_ENABLE)), .en_value(wr_data[STS_BIT]),
    .sts(sts), .en(irq_en), .irq_n(irq_n)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (rd_addr)
      A_STATUS: rd_mux[STS_BIT] = sts;
      A_ENABLE: rd_mux[STS_BIT] = irq_en;
      A_CNT3:   rd_mux = live32[31:24];
      A_CNT2:   rd_mux = snap[23:16];
      A_CNT1:   rd_mux = snap[15:8];
      A_CNT0:   rd_mux = snap[7:0];
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/rei_mon_checks.sv
module rei_mon_checks
  import rei_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              m1_valid,
  input logic [7:0]        m1_byte,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              evt,
  input logic              sts,
  input logic              en,
  input logic              irq_n,
  input logic [CNT_W-1:0]  live
);
  logic rd_s, rd_t;
  assign rd_s = rd_en && (rd_addr == A_STATUS);
  assign rd_t = rd_en && (rd_addr == A_CNT3);

  assert_once_per_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!evt || frame_start));
  assert_zero_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_valid && m1_byte == 8'd0) |-> !evt);
  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> sts);
  assert_step_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_t |=> (live >= $past(live)) && ((live - $past(live)) <= CNT_W'(REI_MAX)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '1 && !rd_t) |=> live == '1);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && !evt) |=> !sts);
  assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && evt) |=> sts);
  assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && en) |-> !irq_n);
  assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts || !en) |-> irq_n);
endmodule

bind rei_line_monitor rei_mon_checks #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .m1_valid(m1_valid),
  .m1_byte(m1_byte), .rd_en(rd_en), .rd_addr(rd_addr), .evt(evt),
  .sts(sts), .en(irq_en), .irq_n(irq_n), .live(live_cnt)
);

// File: tb/tb_rei_line_monitor.sv
`timescale 1ns/1ps
module tb_rei_line_monitor;
  localparam int SMALL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, m1_valid = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] m1_byte = '0, wr_data = '0;
  logic [2:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] rd_data, rd_data_s;
  logic irq_n, irq_n_s;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rei_line_monitor dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .m1_valid(m1_valid),
    .m1_byte(m1_byte), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n));

  rei_line_monitor #(.CNT_W(SMALL_W)) dut_small (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .m1_valid(m1_valid),
    .m1_byte(m1_byte), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n_s));

  // Reference state
  bit m_armed = 1, m_sts = 0, m_en = 0;
  longint unsigned m_cnt [2] = '{0, 0};
  longint unsigned m_snap[2] = '{0, 0};
  longint unsigned m_max [2] = '{64'hFFFF_FFFF, 64'h3FF};
  logic [7:0] m_rd[2] = '{8'h00, 8'h00};

  function automatic logic [7:0] exp_byte(int k, logic [2:0] a);
    case (a)
      3'd0: return {2'b00, m_sts, 5'b0};
      3'd1: return {2'b00, m_en, 5'b0};
      3'd4: return 8'((m_cnt[k] >> 24) & 64'hFF);
      3'd5: return 8'((m_snap[k] >> 16) & 64'hFF);
      3'd6: return 8'((m_snap[k] >> 8) & 64'hFF);
      3'd7: return 8'(m_snap[k] & 64'hFF);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R9";
      3'd4, 3'd5, 3'd6, 3'd7: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit fs, bit mv, logic [7:0] mb, bit rd, logic [2:0] ra,
                      bit wr, logic [2:0] wa, logic [7:0] wd);
    bit acc, ev;
    longint unsigned amt, base;
    @(negedge clk);
    frame_start = fs; m1_valid = mv; m1_byte = mb;
    rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    acc = mv && (m_armed || fs);
    ev  = acc && (mb != 0);
    amt = (mb > 24) ? 24 : mb;
    for (int k = 0; k < 2; k++) begin
      if (rd) m_rd[k] = exp_byte(k, ra);
      base = (rd && ra == 3'd4) ? 0 : m_cnt[k];
      if (rd && ra == 3'd4) m_snap[k] = m_cnt[k];
      if (ev) base = (base + amt > m_max[k]) ? m_max[k] : base + amt;
      m_cnt[k] = base;
    end
    m_armed = fs ? !mv : (m_armed && !mv);
    if (ev) m_sts = 1;
    else if (rd && ra == 3'd0) m_sts = 0;
    if (wr && wa == 3'd1) m_en = wd[5];
    #1;
    check(rd ? tag_of(ra) : "R12", rd_data, m_rd[0]);
    check(rd ? tag_of(ra) : "R12", rd_data_s, m_rd[1]);
    check("R10", {7'b0, irq_n}, {7'b0, !(m_sts && m_en)});
    check("R10", {7'b0, irq_n_s}, {7'b0, !(m_sts && m_en)});
  endtask

  task automatic frame(logic [7:0] v);
    step(1, 1, v, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(logic [2:0] a);
    step(0, 0, 0, 1, a, 0, 0, 0);
  endtask
  task automatic read_count();
    rd(3'd4); rd(3'd5); rd(3'd6); rd(3'd7);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h1A2B3C);
    repeat (4) @(posedge clk);
    #1;
    // R11: reset state
    check("R11", rd_data, 8'h00);
    check("R11", {7'b0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd0); rd(3'd1); read_count();   // R11 zeros everywhere

    // R2: zero produces no event
    frame(8'd0); rd(3'd0); read_count();
    // R3, R4: values 1, 24, 25, 255 (clamped)
    frame(8'd1); frame(8'd24); frame(8'd25); frame(8'd255);
    rd(3'd0); rd(3'd0);                  // R7: set then cleared
    read_count();                         // R6: 73 expected
    // R1: second byte in frame ignored; byte without strobe after first ignored
    frame(8'd5); step(0, 1, 8'd9, 0, 0, 0, 0, 0); step(0, 1, 8'd7, 0, 0, 0, 0, 0);
    read_count();
    step(1, 0, 0, 0, 0, 0, 0, 0); step(0, 1, 8'd3, 0, 0, 0, 0, 0);   // R1 strobe then byte
    // R9, R10: enable and interrupt
    step(0, 0, 0, 0, 0, 1, 3'd1, 8'hFF); rd(3'd1); rd(3'd2); rd(3'd3);  // R12 unmapped
    frame(8'd2);
    // R8: event in the cycle of a status read
    step(1, 1, 8'd4, 1, 3'd0, 0, 0, 0); rd(3'd0); rd(3'd0);
    // R6: event in the cycle of a snapshot read
    frame(8'd6); step(1, 1, 8'd10, 1, 3'd4, 0, 0, 0); rd(3'd7); read_count();
    step(0, 0, 0, 0, 0, 1, 3'd1, 8'h00); frame(8'd1); rd(3'd1);
    // R5: saturate the narrow instance
    for (int i = 0; i < 50; i++) frame(8'd24);
    read_count();
    for (int i = 0; i < 50; i++) frame(8'd200);
    rd(3'd0); read_count();

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      bit fs, mv, rdv, wrv;
      logic [7:0] mb;
      fs  = ($urandom % 4) == 0;
      mv  = ($urandom % 2) == 0;
      mb  = (($urandom % 3) == 0) ? 8'd0 : 8'($urandom % 40);
      rdv = ($urandom % 4) == 0;
      wrv = ($urandom % 16) == 0;
      step(fs, mv, mb, rdv, 3'($urandom % 8), wrv, 3'($urandom % 8), 8'($urandom));
    end
    read_count();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule